// File: doc/BRIEF.md
# Blanking interval timing generator

The block is a free-running generator of horizontal and vertical blanking phases, timed only by the cycle clock. Each axis alternates between a render phase and a blank phase, and each phase length comes from a configuration input. The length is taken when the phase begins, so a new value can be written at any time and applies from the next boundary. Zero-length settings are treated as one cycle.

The two axes run from independent lengths, so a whole number of scanlines does not in general fill a vertical period. To keep the scanlines aligned with the vertical period, the horizontal phase in progress is lengthened by a programmed adjustment each time the vertical blank begins. The block gives four single-cycle strobes for use by gated timers: horizontal blank start and end, and vertical blank start and end. It also keeps a frame counter and two sticky status flags, each with a maskable interrupt pulse. The line flag is set when horizontal blank ends. The field flag is set when vertical blank starts. Software clears each flag through its own write-1-to-clear input.

Top module: `blank_timing_gen`

## Requirements
- R1: While reset is asserted, all outputs are 0: both blank levels, the four strobes, both flags, both interrupts and the frame count.
- R2: After reset the horizontal axis starts in render (h_blank = 0). It then alternates: render lasts h_render_len cycles and blank lasts h_blank_len cycles. The first sample of h_blank = 1 comes h_render_len cycles after the first clock edge with reset released.
- R3: The vertical axis alternates in the same way, with v_render_len and v_blank_len, and also starts in render.
- R4: On the clock edge where vertical blank begins, the horizontal phase in progress, or the one starting on that same edge, is lengthened by h_adjust cycles. Every later horizontal boundary therefore moves by h_adjust.
- R5: Each strobe (h_blank_start, h_blank_end, v_blank_start, v_blank_end) is high for exactly the first cycle of the phase it names: start with blank = 1, end with blank = 0.
- R6: frame_count increments by one, modulo 2^FRAME_W, in the cycle where v_blank_end is high, and holds otherwise.
- R7: line_flag becomes 1 in the cycle h_blank_end is high. It stays 1 until a cycle with line_flag_clr = 1 is clocked. line_irq is a one-cycle pulse, raised with that set only if line_flag was 0 before and line_irq_mask was 0.
- R8: field_flag and field_irq behave in the same way, triggered by v_blank_start and governed by field_flag_clr and field_irq_mask.
- R9: When a flag's clear input and its set event fall on the same edge, the flag is 1 afterwards.
- R10: A phase length is sampled when its phase begins. Changing the configuration mid-phase does not alter the current phase.
- R11: A length input of 0 behaves as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_render_len | input | LEN_W | Horizontal render phase length in cycles |
| h_blank_len | input | LEN_W | Horizontal blank phase length in cycles |
| v_render_len | input | LEN_W | Vertical render phase length in cycles |
| v_blank_len | input | LEN_W | Vertical blank phase length in cycles |
| h_adjust | input | ADJ_W | Cycles added to the horizontal phase at each vertical blank start |
| line_irq_mask | input | 1 | 1 suppresses line_irq |
| field_irq_mask | input | 1 | 1 suppresses field_irq |
| line_flag_clr | input | 1 | Write-1-to-clear for line_flag |
| field_flag_clr | input | 1 | Write-1-to-clear for field_flag |
| h_blank | output | 1 | Horizontal blank level |
| v_blank | output | 1 | Vertical blank level |
| h_blank_start | output | 1 | First cycle of horizontal blank |
| h_blank_end | output | 1 | First cycle of horizontal render |
| v_blank_start | output | 1 | First cycle of vertical blank |
| v_blank_end | output | 1 | First cycle of vertical render |
| line_flag | output | 1 | Sticky horizontal status |
| field_flag | output | 1 | Sticky vertical status |
| line_irq | output | 1 | Horizontal interrupt pulse |
| field_irq | output | 1 | Vertical interrupt pulse |
| frame_count | output | FRAME_W | Count of completed vertical blanks |

## Verification
The bench builds its own event timetable and compares it with the outputs in every cycle. One configuration places a vertical blank start on the same edge as a horizontal boundary. A design that applied the adjustment to the wrong phase, or skipped it in that case, would shift every later horizontal strobe. Zero lengths are run as well: a design without the clamp to one cycle would stall or count through a full wrap.

A mid-phase rewrite of the lengths catches a design that reads the inputs continuously, because the current phase would be cut short or stretched. The flag scenarios target masking, one-cycle interrupts, no re-interrupt while a flag is still set, and the case where a clear and a set fall on the same edge. A design where the clear wins there would lose an event.

// File: rtl/blank_timing_pkg.sv
package blank_timing_pkg;

  typedef enum logic {
    PH_RENDER = 1'b0,
    PH_BLANK  = 1'b1
  } phase_e;

  // A programmed length of zero is served as one cycle.
  function automatic logic [31:0] eff_len(input logic [31:0] len);
    return (len == 32'd0) ? 32'd1 : len;
  endfunction

  // Length of the phase that follows the given one.
  function automatic logic [31:0] follow_len(input phase_e cur,
                                             input logic [31:0] render_len,
                                             input logic [31:0] blank_len);
    return (cur == PH_BLANK) ? eff_len(render_len) : eff_len(blank_len);
  endfunction

endpackage

// File: rtl/blank_axis.sv
module blank_axis
  import blank_timing_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int ADJ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] render_len,
  input  logic [LEN_W-1:0] blank_len,
  input  logic [ADJ_W-1:0] adj,
  input  logic             adj_en,
  output phase_e           phase_o,
  output logic             to_blank_o,
  output logic             to_render_o
);
  localparam int CNT_W = ((LEN_W > ADJ_W) ? LEN_W : ADJ_W) + 2;

  logic             loaded_q;
  phase_e           phase_q;
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] extra;
  logic             last;

  always_comb begin
    last  = loaded_q && (left_q == CNT_W'(1));
    extra = adj_en ? CNT_W'(adj) : '0;
    if (!loaded_q)
      base = CNT_W'(eff_len(32'(render_len)));
    else if (last)
      base = CNT_W'(follow_len(phase_q, 32'(render_len), 32'(blank_len)));
    else
      base = left_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      phase_q  <= PH_RENDER;
      left_q   <= '0;
    end else begin
      loaded_q <= 1'b1;
      left_q   <= base + extra;
      if (last)
        phase_q <= (phase_q == PH_RENDER) ? PH_BLANK : PH_RENDER;
    end
  end

  assign phase_o     = phase_q;
  assign to_blank_o  = last && (phase_q == PH_RENDER);
  assign to_render_o = last && (phase_q == PH_BLANK);
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr_i);
      irq_q  <= set_i & ~flag_q & ~mask_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/blank_timing_gen.sv
module blank_timing_gen
  import blank_timing_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int ADJ_W   = 16,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEN_W-1:0]   h_render_len,
  input  logic [LEN_W-1:0]   h_blank_len,
  input  logic [LEN_W-1:0]   v_render_len,
  input  logic [LEN_W-1:0]   v_blank_len,
  input  logic [ADJ_W-1:0]   h_adjust,
  input  logic               line_irq_mask,
  input  logic               field_irq_mask,
  input  logic               line_flag_clr,
  input  logic               field_flag_clr,
  output logic               h_blank,
  output logic               v_blank,
  output logic               h_blank_start,
  output logic               h_blank_end,
  output logic               v_blank_start,
  output logic               v_blank_end,
  output logic               line_flag,
  output logic               field_flag,
  output logic               line_irq,
  output logic               field_irq,
  output logic [FRAME_W-1:0] frame_count
);
  phase_e h_phase;
  phase_e v_phase;
  logic   h_to_blank;
  logic   h_to_render;
  logic   v_to_blank;
  logic   v_to_render;

  logic               hbs_q, hbe_q, vbs_q, vbe_q;
  logic [FRAME_W-1:0] frame_q;

  blank_axis #(.LEN_W(LEN_W), .ADJ_W(ADJ_W)) u_h_axis (
    .clk(clk), .rst_n(rst_n),
    .render_len(h_render_len), .blank_len(h_blank_len),
    .adj(h_adjust), .adj_en(v_to_blank),
    .phase_o(h_phase), .to_blank_o(h_to_blank), .to_render_o(h_to_render)
  );

  blank_axis #(.LEN_W(LEN_W), .ADJ_W(ADJ_W)) u_v_axis (
    .clk(clk), .rst_n(rst_n),
    .render_len(v_render_len), .blank_len(v_blank_len),
    .adj('0), .adj_en(1'b0),
    .phase_o(v_phase), .to_blank_o(v_to_blank), .to_render_o(v_to_render)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hbs_q   <= 1'b0;
      hbe_q   <= 1'b0;
      vbs_q   <= 1'b0;
      vbe_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      hbs_q <= h_to_blank;
      hbe_q <= h_to_render;
      vbs_q <= v_to_blank;
      vbe_q <= v_to_render;
      if (v_to_render)
        frame_q <= frame_q + FRAME_W'(1);
    end
  end

  sticky_flag u_line_flag (
    .clk(clk), .rst_n(rst_n), .set_i(h_to_render), .clr_i(line_flag_clr),
    .mask_i(line_irq_mask), .flag_o(line_flag), .irq_o(line_irq)
  );

  sticky_flag u_field_flag (
    .clk(clk), .rst_n(rst_n), .set_i(v_to_blank), .clr_i(field_flag_clr),
    .mask_i(field_irq_mask), .flag_o(field_flag), .irq_o(field_irq)
  );

  assign h_blank       = (h_phase == PH_BLANK);
  assign v_blank       = (v_phase == PH_BLANK);
  assign h_blank_start = hbs_q;
  assign h_blank_end   = hbe_q;
  assign v_blank_start = vbs_q;
  assign v_blank_end   = vbe_q;
  assign frame_count   = frame_q;
endmodule

// File: rtl/blank_timing_chk.sv
module blank_timing_chk #(
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               h_blank,
  input logic               v_blank,
  input logic               h_blank_start,
  input logic               h_blank_end,
  input logic               v_blank_start,
  input logic               v_blank_end,
  input logic               line_flag,
  input logic               field_flag,
  input logic               line_irq,
  input logic               field_irq,
  input logic               line_irq_mask,
  input logic               field_irq_mask,
  input logic               line_flag_clr,
  input logic               field_flag_clr,
  input logic [FRAME_W-1:0] frame_count,
  input logic               h_evt_to_blank,
  input logic               h_evt_to_render,
  input logic               v_evt_to_blank,
  input logic               v_evt_to_render
);
  a_r5_hbs_level: assert property (@(posedge clk) disable iff (!rst_n)
    h_blank_start |-> h_blank);
  a_r5_hbe_level: assert property (@(posedge clk) disable iff (!rst_n)
    h_blank_end |-> !h_blank);
  a_r2_h_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_blank) |-> h_blank_start);
  a_r2_h_fall_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h_blank) |-> h_blank_end);
  a_r3_v_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_blank) |-> v_blank_start);
  a_r3_v_fall_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v_blank) |-> v_blank_end);
  a_r5_hbs_single: assert property (@(posedge clk) disable iff (!rst_n)
    h_blank_start |=> !h_blank_start);
  a_r5_vbs_single: assert property (@(posedge clk) disable iff (!rst_n)
    v_blank_start |=> !v_blank_start);
  a_r5_h_event_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    h_evt_to_blank |=> h_blank_start);
  a_r5_v_event_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    v_evt_to_render |=> v_blank_end);
  a_r6_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    v_blank_end |-> frame_count == $past(frame_count) + FRAME_W'(1));
  a_r6_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v_blank_end |-> $stable(frame_count));
  a_r7_line_irq_edge: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |-> line_flag && !$past(line_flag) && !$past(line_irq_mask));
  a_r7_line_set_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    h_evt_to_render |=> line_flag);
  a_r7_line_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_flag) |-> $past(line_flag_clr));
  a_r8_field_irq_edge: assert property (@(posedge clk) disable iff (!rst_n)
    field_irq |-> field_flag && !$past(field_flag) && !$past(field_irq_mask));
  a_r8_field_set_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    v_evt_to_blank |=> field_flag);
  a_r8_field_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(field_flag) |-> $past(field_flag_clr));
endmodule

bind blank_timing_gen blank_timing_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .h_blank(h_blank), .v_blank(v_blank),
  .h_blank_start(h_blank_start), .h_blank_end(h_blank_end),
  .v_blank_start(v_blank_start), .v_blank_end(v_blank_end),
  .line_flag(line_flag), .field_flag(field_flag),
  .line_irq(line_irq), .field_irq(field_irq),
  .line_irq_mask(line_irq_mask), .field_irq_mask(field_irq_mask),
  .line_flag_clr(line_flag_clr), .field_flag_clr(field_flag_clr),
  .frame_count(frame_count),
  .h_evt_to_blank(h_to_blank), .h_evt_to_render(h_to_render),
  .v_evt_to_blank(v_to_blank), .v_evt_to_render(v_to_render)
);

// File: tb/test_blank_timing_gen.sv
module test_blank_timing_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] h_render_len = 16'd5, h_blank_len = 16'd4;
  logic [15:0] v_render_len = 16'd40, v_blank_len = 16'd30;
  logic [15:0] h_adjust = 16'd0;
  logic        line_irq_mask = 1'b0, field_irq_mask = 1'b0;
  logic        line_flag_clr = 1'b0, field_flag_clr = 1'b0;
  wire         h_blank, v_blank, h_blank_start, h_blank_end;
  wire         v_blank_start, v_blank_end, line_flag, field_flag, line_irq, field_irq;
  wire  [15:0] frame_count;

  int checks = 0;
  int fails  = 0;

  blank_timing_gen i_blank_timing_gen (
    .clk(clk), .rst_n(rst_n),
    .h_render_len(h_render_len), .h_blank_len(h_blank_len),
    .v_render_len(v_render_len), .v_blank_len(v_blank_len),
    .h_adjust(h_adjust),
    .line_irq_mask(line_irq_mask), .field_irq_mask(field_irq_mask),
    .line_flag_clr(line_flag_clr), .field_flag_clr(field_flag_clr),
    .h_blank(h_blank), .v_blank(v_blank),
    .h_blank_start(h_blank_start), .h_blank_end(h_blank_end),
    .v_blank_start(v_blank_start), .v_blank_end(v_blank_end),
    .line_flag(line_flag), .field_flag(field_flag),
    .line_irq(line_irq), .field_irq(field_irq),
    .frame_count(frame_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int eff(input int len);
    return (len == 0) ? 1 : len;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // 0: h_blank_start 1: h_blank_end 2: v_blank_start 3: v_blank_end
  task automatic wait_evt(input int which, output int cyc);
    cyc = 0;
    for (int k = 0; k < 5000; k++) begin
      logic s;
      @(negedge clk);
      cyc++;
      case (which)
        0: s = h_blank_start;
        1: s = h_blank_end;
        2: s = v_blank_start;
        default: s = v_blank_end;
      endcase
      if (s === 1'b1) break;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 h_blank", h_blank, 0);
    chk("R1 v_blank", v_blank, 0);
    chk("R1 strobes", {h_blank_start, h_blank_end, v_blank_start, v_blank_end}, 0);
    chk("R1 flags", {line_flag, field_flag, line_irq, field_irq}, 0);
    chk("R1 frame_count", frame_count, 0);
  endtask

  // Cycle-accurate timetable check; sample n is the negedge after the n-th
  // rising edge counted from the first one with reset released.
  task automatic run_sched(input int hr, input int hb, input int vr, input int vb,
                           input int adj, input int ncyc, input string tag);
    int h_next, v_next, fc;
    bit h_is_start, v_is_start, e_hbl, e_vbl;
    h_render_len = 16'(hr); h_blank_len = 16'(hb);
    v_render_len = 16'(vr); v_blank_len = 16'(vb);
    h_adjust = 16'(adj);
    do_reset();
    h_next = eff(hr); h_is_start = 1'b1;
    v_next = eff(vr); v_is_start = 1'b1;
    fc = 0; e_hbl = 1'b0; e_vbl = 1'b0;
    for (int n = 0; n < ncyc; n++) begin
      bit ehs, ehe, evs, eve;
      @(negedge clk);
      ehs = (n == h_next) && h_is_start;
      ehe = (n == h_next) && !h_is_start;
      evs = (n == v_next) && v_is_start;
      eve = (n == v_next) && !v_is_start;
      if (n == h_next) e_hbl = h_is_start;
      if (n == v_next) e_vbl = v_is_start;
      if (eve) fc++;
      chk({tag, " R2 h_blank"}, h_blank, e_hbl);
      chk({tag, " R3 v_blank"}, v_blank, e_vbl);
      chk({tag, " R5 h_blank_start"}, h_blank_start, ehs);
      chk({tag, " R5 h_blank_end"}, h_blank_end, ehe);
      chk({tag, " R5 v_blank_start"}, v_blank_start, evs);
      chk({tag, " R5 v_blank_end"}, v_blank_end, eve);
      chk({tag, " R6 frame_count"}, frame_count, fc & 16'hFFFF);
      if (n == h_next) begin
        h_next = n + (h_is_start ? eff(hb) : eff(hr));
        h_is_start = !h_is_start;
      end
      if (n == v_next) begin
        v_next = n + (v_is_start ? eff(vb) : eff(vr));
        v_is_start = !v_is_start;
      end
      if (evs) h_next += adj;   // R4 stretch of the pending horizontal phase
    end
  endtask

  task automatic t_basic();
    run_sched(5, 4, 40, 30, 0, 300, "basic");
  endtask

  task automatic t_adjust();
    run_sched(7, 2, 23, 11, 3, 400, "adjust R4");
    run_sched(5, 4, 27, 18, 2, 300, "coincident R4");
  endtask

  task automatic t_zero_len();
    run_sched(0, 0, 10, 0, 0, 150, "zero R11");
  endtask

  task automatic t_latch();
    int c;
    h_render_len = 16'd5; h_blank_len = 16'd4;
    v_render_len = 16'd1000; v_blank_len = 16'd1000; h_adjust = 16'd0;
    do_reset();
    wait_evt(0, c);
    h_blank_len = 16'd9; h_render_len = 16'd2;
    wait_evt(1, c);
    chk("R10 blank kept old length", c, 4);
    wait_evt(0, c);
    chk("R10 render takes new length", c, 2);
    wait_evt(1, c);
    chk("R10 blank takes new length", c, 9);
  endtask

  task automatic t_line_flag();
    int c;
    h_render_len = 16'd3; h_blank_len = 16'd3;
    v_render_len = 16'd1000; v_blank_len = 16'd1000; h_adjust = 16'd0;
    line_irq_mask = 1'b0; line_flag_clr = 1'b0;
    do_reset();
    wait_evt(1, c);
    chk("R7 flag set at blank end", line_flag, 1);
    chk("R7 irq on first set", line_irq, 1);
    @(negedge clk);
    chk("R7 irq one cycle", line_irq, 0);
    wait_evt(1, c);
    chk("R7 flag still set", line_flag, 1);
    chk("R7 no irq while set", line_irq, 0);
    @(negedge clk); line_flag_clr = 1'b1;
    @(negedge clk); line_flag_clr = 1'b0;
    chk("R7 clear input", line_flag, 0);
    line_irq_mask = 1'b1;
    wait_evt(1, c);
    chk("R7 masked flag set", line_flag, 1);
    chk("R7 masked irq low", line_irq, 0);
    @(negedge clk); line_flag_clr = 1'b1;
    @(negedge clk);
    line_irq_mask = 1'b0;
    wait_evt(1, c);
    chk("R9 set wins over clear", line_flag, 1);
    chk("R9 irq with clear held", line_irq, 1);
    @(negedge clk);
    chk("R9 clear acts next cycle", line_flag, 0);
    line_flag_clr = 1'b0;
  endtask

  task automatic t_field_flag();
    int c;
    h_render_len = 16'd3; h_blank_len = 16'd3;
    v_render_len = 16'd6; v_blank_len = 16'd5; h_adjust = 16'd0;
    field_irq_mask = 1'b0; field_flag_clr = 1'b0;
    do_reset();
    wait_evt(2, c);
    chk("R8 flag set at blank start", field_flag, 1);
    chk("R8 irq on first set", field_irq, 1);
    @(negedge clk); field_flag_clr = 1'b1;
    @(negedge clk); field_flag_clr = 1'b0;
    chk("R8 clear input", field_flag, 0);
    field_irq_mask = 1'b1;
    wait_evt(2, c);
    chk("R8 masked flag set", field_flag, 1);
    chk("R8 masked irq low", field_irq, 0);
    field_irq_mask = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_adjust();
    t_zero_len();
    t_latch();
    t_line_flag();
    t_field_flag();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule